// File: doc/BRIEF.md
# Receive Descriptor Chain Walker

This block is the descriptor-handling half of a receive DMA engine. A small descriptor RAM sits inside it and is reachable word by word from a host port. Each descriptor is four 32-bit words:

- word 0 holds the ownership bit and the status that the engine writes back;
- word 1 holds the buffer size and a mode flag that selects chained or sequential linking;
- word 2 holds the buffer address, which the engine does not interpret;
- word 3 holds the next-descriptor pointer.

Software builds a list of descriptors, sets their ownership bits and supplies a start address. Raising the enable makes the engine load the start address and check the ownership bit of the descriptor found there.

While the engine owns the current descriptor it signals that it can take a frame. Each frame arrives as a single event that carries its length and an error indication. For each accepted frame the engine does the following:

- It writes the status word, with ownership handed back, first and last flags, the length and an error-summary bit.
- It raises a sticky receive-complete flag.
- It moves to the next descriptor, either through the pointer in word 3 or to the adjacent descriptor.

If the engine meets a descriptor that it does not own, it raises a sticky buffer-unavailable flag and suspends. It stays suspended until a poll-demand pulse arrives. Payload movement and the bus fabric are not part of this block.

Top module: `rxd_walker`

## Requirements
- R1: After reset rc_flag, bu_flag and frm_ready are all 0; with rx_en low the engine stays idle and frm_ready stays 0.
- R2: When rx_en rises from the idle state the first descriptor examined is the one at base_addr, with base_addr bits [1:0] ignored (descriptors are four-word aligned).
- R3: While the current descriptor has word 0 bit 31 (ownership) set, frm_ready is 1. A frame accepted with frm_valid is written back as word 0 as follows: bit 31 = 0, bits [29:16] = length, bit 15 = error summary (equal to frm_err), bit 9 = first = 1, bit 8 = last = 1, all other bits 0.
- R4: If frm_len exceeds the buffer size in word 1 bits [12:0], the length written back equals the buffer size and bit 15 is set even when frm_err is 0.
- R5: When the current descriptor is not owned, bu_flag becomes 1 and frm_ready stays 0. Frames presented while stalled are ignored and the descriptor is not written.
- R6: Only a poll_dmd pulse clears bu_flag. That pulse makes the engine re-examine the same descriptor, and the engine stalls again if that descriptor is still not owned. A poll_dmd pulse while a frame is awaited has no effect on the walk.
- R7: rc_flag is set by every accepted frame and cleared by a rc_clr pulse; when both happen in the same cycle rc_flag ends up 1.
- R8: After a writeback the next descriptor depends on word 1 bit 14. When the bit is 1 it is the word-3 pointer with bits [1:0] ignored. When the bit is 0 it is the current address plus 4, wrapping modulo the RAM depth.
- R9: A host write stores hst_wdata at hst_addr, and hst_rdata returns the addressed word one cycle after the address is presented. If a host write and a writeback hit the same word in one cycle, the writeback value is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable; rising from idle loads base_addr |
| base_addr | input | AW | Word address of the first descriptor |
| poll_dmd | input | 1 | Poll-demand pulse, resumes a stalled walk |
| rc_clr | input | 1 | Clears the receive-complete flag |
| frm_valid | input | 1 | A frame is offered this cycle |
| frm_len | input | 14 | Byte length of the offered frame |
| frm_err | input | 1 | Offered frame was received with errors |
| frm_ready | output | 1 | Engine owns the current descriptor and can take a frame |
| rc_flag | output | 1 | Sticky receive-complete flag |
| bu_flag | output | 1 | Sticky buffer-unavailable flag |
| hst_we | input | 1 | Host write strobe |
| hst_addr | input | AW | Host word address into descriptor RAM |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Registered host read data |

## Verification
Two collisions are provoked on purpose.

- A rc_clr pulse is driven in the very cycle a frame is accepted. The bench then expects rc_flag to remain 1, because setting wins.
- A host write to the status word of the current descriptor is driven in the cycle of the writeback. Reading that word back must return the engine's status rather than the host's value.

A poll_dmd pulse is also driven alongside frame acceptance while the engine is armed. The bench judges it by the walk still reaching the descriptor it predicts.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
    localparam int WORD_W  = 32;
    localparam int OWN_BIT = 31;
    localparam int LEN_LSB = 16;
    localparam int LEN_W   = 14;
    localparam int ES_BIT  = 15;
    localparam int FD_BIT  = 9;
    localparam int LD_BIT  = 8;
    localparam int BSZ_W   = 13;
    localparam int CHN_BIT = 14;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_CHECK,
        ST_ARMED,
        ST_FOLLOW,
        ST_STALL
    } walk_st_t;
endpackage

// File: rtl/rxd_desc_ram.sv
module rxd_desc_ram #(
    parameter int DEPTH = 64,
    parameter int NRD   = 2,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      h_we,
    input  logic [AW-1:0]             h_addr,
    input  logic [rxd_pkg::WORD_W-1:0] h_wdata,
    output logic [rxd_pkg::WORD_W-1:0] h_rdata,
    input  logic                      e_we,
    input  logic [AW-1:0]             e_addr,
    input  logic [rxd_pkg::WORD_W-1:0] e_wdata,
    input  logic [AW-1:0]             e_raddr [NRD],
    output logic [rxd_pkg::WORD_W-1:0] e_rdata [NRD]
);
    logic [rxd_pkg::WORD_W-1:0] mem_q [DEPTH];
    logic host_blocked;

    // engine writeback wins a same-word collision (R9)
    assign host_blocked = e_we && (e_addr == h_addr);

    always_ff @(posedge clk) begin
        if (e_we)
            mem_q[e_addr] <= e_wdata;
        if (h_we && !host_blocked)
            mem_q[h_addr] <= h_wdata;
        h_rdata <= mem_q[h_addr];
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign e_rdata[g] = mem_q[e_raddr[g]];
    end
endmodule

// File: rtl/rxd_wb_format.sv
module rxd_wb_format
    import rxd_pkg::*;
(
    input  logic [LEN_W-1:0]  frm_len,
    input  logic              frm_err,
    input  logic [BSZ_W-1:0]  bsize,
    output logic [WORD_W-1:0] wb_word,
    output logic              trunc
);
    logic [LEN_W-1:0] len_eff;

    always_comb begin
        trunc   = frm_len > LEN_W'(bsize);
        len_eff = trunc ? LEN_W'(bsize) : frm_len;
        wb_word = '0;
        wb_word[LEN_LSB +: LEN_W] = len_eff;
        wb_word[ES_BIT] = frm_err | trunc;
        wb_word[FD_BIT] = 1'b1;
        wb_word[LD_BIT] = 1'b1;
    end
endmodule

// File: rtl/rxd_flag.sv
module rxd_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr) flag_d = 1'b0;
        if (set) flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;
endmodule

// File: rtl/rxd_walker.sv
module rxd_walker
    import rxd_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic [AW-1:0]     base_addr,
    input  logic              poll_dmd,
    input  logic              rc_clr,
    input  logic              frm_valid,
    input  logic [LEN_W-1:0]  frm_len,
    input  logic              frm_err,
    output logic              frm_ready,
    output logic              rc_flag,
    output logic              bu_flag,
    input  logic              hst_we,
    input  logic [AW-1:0]     hst_addr,
    input  logic [WORD_W-1:0] hst_wdata,
    output logic [WORD_W-1:0] hst_rdata
);
    typedef struct packed {
        walk_st_t      st;
        logic [AW-1:0] cur;
    } walk_t;

    walk_t d, q;

    logic              accept, bu_set, e_we;
    logic [AW-1:0]     raddr [2];
    logic [WORD_W-1:0] rdata [2];
    logic [WORD_W-1:0] wb_word;
    logic              trunc;
    logic [AW-1:0]     next_ptr;

    rxd_desc_ram #(.DEPTH(DEPTH), .NRD(2)) u_ram (
        .clk     (clk),
        .h_we    (hst_we),
        .h_addr  (hst_addr),
        .h_wdata (hst_wdata),
        .h_rdata (hst_rdata),
        .e_we    (e_we),
        .e_addr  (q.cur),
        .e_wdata (wb_word),
        .e_raddr (raddr),
        .e_rdata (rdata)
    );

    rxd_wb_format u_fmt (
        .frm_len (frm_len),
        .frm_err (frm_err),
        .bsize   (rdata[1][BSZ_W-1:0]),
        .wb_word (wb_word),
        .trunc   (trunc)
    );

    rxd_flag u_rc (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (accept),
        .clr   (rc_clr),
        .flag  (rc_flag)
    );

    rxd_flag u_bu (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (bu_set),
        .clr   (poll_dmd),
        .flag  (bu_flag)
    );

    assign frm_ready = (q.st == ST_ARMED) && rx_en;
    assign next_ptr  = {rdata[0][AW-1:2], 2'b00};

    always_comb begin
        d        = q;
        accept   = 1'b0;
        bu_set   = 1'b0;
        e_we     = 1'b0;
        raddr[0] = q.cur;
        raddr[1] = {q.cur[AW-1:2], 2'b01};
        case (q.st)
            ST_OFF: begin
                if (rx_en) begin
                    d.cur = {base_addr[AW-1:2], 2'b00};
                    d.st  = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (rdata[0][OWN_BIT] && !bu_flag) begin
                    d.st = ST_ARMED;
                end else begin
                    bu_set = 1'b1;
                    d.st   = ST_STALL;
                end
            end
            ST_ARMED: begin
                if (frm_valid && rx_en) begin
                    accept = 1'b1;
                    e_we   = 1'b1;
                    d.st   = ST_FOLLOW;
                end
            end
            ST_FOLLOW: begin
                raddr[0] = {q.cur[AW-1:2], 2'b11};
                if (rdata[1][CHN_BIT]) d.cur = next_ptr;
                else                   d.cur = q.cur + AW'(4);
                d.st = ST_CHECK;
            end
            ST_STALL: begin
                if (poll_dmd) d.st = ST_CHECK;
            end
            default: d.st = ST_OFF;
        endcase
        if (!rx_en) d.st = ST_OFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st  <= ST_OFF;
            q.cur <= '0;
        end else begin
            q <= d;
        end
    end

    // R1: a disabled engine never offers to take a frame
    a_r1_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !frm_ready);

    // R4: written length never exceeds the buffer size, overflow marks an error
    a_r4_len_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (wb_word[LEN_LSB +: LEN_W] <= LEN_W'(rdata[1][BSZ_W-1:0])));
    a_r4_trunc_err: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && trunc) |-> wb_word[ES_BIT]);

    // R5: no frame is taken while buffer-unavailable is raised
    a_r5_stalled_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        bu_flag |-> !frm_ready);

    // R6: buffer-unavailable holds until a poll demand
    a_r6_bu_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (bu_flag && !poll_dmd) |=> bu_flag);

    // R7: every accepted frame leaves receive-complete set
    a_r7_rc_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && frm_ready) |=> rc_flag);
endmodule

// File: tb/sim_rxd_walker.sv
`timescale 1ns/1ps
module sim_rxd_walker;
    localparam int DEPTH = 64;
    localparam int AW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_en = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic poll_dmd = 1'b0, rc_clr = 1'b0;
    logic frm_valid = 1'b0, frm_err = 1'b0;
    logic [13:0] frm_len = '0;
    logic frm_ready, rc_flag, bu_flag;
    logic hst_we = 1'b0;
    logic [AW-1:0] hst_addr = '0;
    logic [31:0] hst_wdata = '0, hst_rdata;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rxd_walker #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .base_addr(base_addr),
        .poll_dmd(poll_dmd), .rc_clr(rc_clr), .frm_valid(frm_valid),
        .frm_len(frm_len), .frm_err(frm_err), .frm_ready(frm_ready),
        .rc_flag(rc_flag), .bu_flag(bu_flag), .hst_we(hst_we),
        .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata)
    );

    function automatic logic [31:0] exp_wb(int len, bit err, int bsz);
        logic [31:0] w;
        bit tr;
        tr = len > bsz;
        w = '0;
        w[29:16] = 14'(tr ? bsz : len);
        w[15] = err | tr;
        w[9] = 1'b1;
        w[8] = 1'b1;
        return w;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic hwrite(int a, logic [31:0] v);
        hst_we = 1'b1; hst_addr = AW'(a); hst_wdata = v;
        @(negedge clk);
        hst_we = 1'b0;
    endtask

    task automatic hread(int a, output logic [31:0] v);
        hst_addr = AW'(a);
        @(negedge clk);
        v = hst_rdata;
    endtask

    task automatic mkdesc(int a, bit own, int bsz, bit chain, int nxt);
        hwrite(a, own ? 32'h8000_0000 : 32'h0);
        hwrite(a + 1, {17'b0, chain, 1'b0, 13'(bsz)});
        hwrite(a + 2, 32'h1000_0000 + 32'(a));
        hwrite(a + 3, 32'(nxt));
    endtask

    task automatic send(int len, bit err, bit clr, bit poll, bit hw, int hwa);
        int t;
        t = 0;
        while (!frm_ready && t < 200) begin
            @(negedge clk);
            t++;
        end
        if (!frm_ready) begin
            checks++; errors++;
            $display("FAIL R3 frm_ready actual=0 expected=1 (timeout)");
        end
        frm_valid = 1'b1; frm_len = 14'(len); frm_err = err;
        rc_clr = clr; poll_dmd = poll;
        if (hw) begin
            hst_we = 1'b1; hst_addr = AW'(hwa); hst_wdata = 32'hDEAD_BEEF;
        end
        @(negedge clk);
        frm_valid = 1'b0; rc_clr = 1'b0; poll_dmd = 1'b0; hst_we = 1'b0;
    endtask

    task automatic pulse_poll();
        poll_dmd = 1'b1;
        @(negedge clk);
        poll_dmd = 1'b0;
    endtask

    initial begin
        #(190000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int seqa [4];
        int bsz [4];
        int idx, len;
        bit err;
        void'($urandom(32'd1234));

        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        chk("R1 rc_flag", 32'(rc_flag), 0);
        chk("R1 bu_flag", 32'(bu_flag), 0);
        chk("R1 frm_ready", 32'(frm_ready), 0);

        // chained list: 8 -> 20 -> 12 -> 8 (pointer 14 has junk low bits)
        mkdesc(8, 1, 100, 1, 20);
        mkdesc(20, 1, 30, 1, 14);
        mkdesc(12, 1, 200, 1, 8);
        hread(10, v);
        chk("R9 host readback", v, 32'h1000_0008);
        cyc(3);
        chk("R1 idle with rx_en low", 32'(frm_ready), 0);

        base_addr = 6'd9;
        rx_en = 1'b1;
        send(64, 0, 0, 0, 0, 0);
        chk("R7 rc set", 32'(rc_flag), 1);
        hread(8, v);
        chk("R2 R3 first descriptor writeback", v, exp_wb(64, 0, 100));
        rc_clr = 1'b1; @(negedge clk); rc_clr = 1'b0;
        chk("R7 rc cleared", 32'(rc_flag), 0);

        send(50, 0, 0, 0, 0, 0);
        hread(20, v);
        chk("R4 truncated writeback", v, exp_wb(50, 0, 30));
        chk("R4 length equals buffer", 32'(v[29:16]), 30);
        rc_clr = 1'b1; @(negedge clk); rc_clr = 1'b0;

        send(10, 1, 1, 0, 0, 0);
        chk("R7 set wins over clear", 32'(rc_flag), 1);
        hread(12, v);
        chk("R3 R8 error frame via masked pointer", v, exp_wb(10, 1, 200));

        // next is 8, now not owned
        cyc(4);
        chk("R5 bu set", 32'(bu_flag), 1);
        chk("R5 not ready", 32'(frm_ready), 0);
        frm_valid = 1'b1; frm_len = 14'd5;
        cyc(4);
        frm_valid = 1'b0;
        hread(8, v);
        chk("R5 stalled descriptor untouched", v, exp_wb(64, 0, 100));

        pulse_poll();
        cyc(4);
        chk("R6 repoll still stalled", 32'(bu_flag), 1);
        hwrite(8, 32'h8000_0000);
        cyc(4);
        chk("R6 bu sticky after giveback", 32'(bu_flag), 1);
        chk("R6 not ready before poll", 32'(frm_ready), 0);
        pulse_poll();
        cyc(3);
        chk("R6 bu cleared by poll", 32'(bu_flag), 0);
        chk("R6 ready after poll", 32'(frm_ready), 1);

        send(77, 0, 0, 0, 1, 8);
        hread(8, v);
        chk("R9 writeback beats host write", v, exp_wb(77, 0, 100));
        cyc(4);
        rx_en = 1'b0;
        cyc(2);
        chk("R1 off after disable", 32'(frm_ready), 0);

        // sequential list 52,56,60 then wrap to 0, 0 chains back to 52
        seqa = '{52, 56, 60, 0};
        for (int k = 0; k < 4; k++) begin
            bsz[k] = 20 + int'($urandom_range(0, 280));
            mkdesc(seqa[k], 1, bsz[k], k == 3, 52);
        end
        base_addr = 6'd52;
        rx_en = 1'b1;
        cyc(4);
        chk("R5 stays stalled while bu set", 32'(frm_ready), 0);
        pulse_poll();

        idx = 0;
        for (int i = 0; i < 24; i++) begin
            len = 1 + int'($urandom_range(0, 299));
            err = ($urandom_range(0, 3) == 0);
            send(len, err, 0, (i % 3) == 1, 0, 0);
            chk("R7 rc per frame", 32'(rc_flag), 1);
            hread(seqa[idx], v);
            chk("R8 R3 walk writeback", v, exp_wb(len, err, bsz[idx]));
            hwrite(seqa[idx], 32'h8000_0000);
            idx = (idx + 1) % 4;
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule